// File: doc/BRIEF.md
# Shadowed Configuration Register Bank

This block holds the configuration registers of one display output channel in two copies. Software writes a staged (shadow) copy at any time through a plain write port. The display pipeline reads only the live (active) copy, so a half-written setup never reaches it. After software has staged every register it needs, it raises a single request flag. The next frame boundary of the channel then moves the whole staged set into the live copy in one clock edge. Hardware drops the flag at that moment, and software polls the flag to see that the switch has happened.

A parameter picks the kind of channel. A panel channel switches on the start of its vertical front porch. A TV channel switches on the external vertical sync pulse. A rising edge on the interface enable input also forces a switch, whatever the state of the request flag. A per-register mask marks which registers are double-buffered. An unmasked register writes straight through to its live copy. The write port, the request pulse and the sync inputs are plain control pins with no handshake, and a write is taken in every cycle in which `cfg_we` is high. The block never stalls a write and has no back-pressure.

Top module: `shadow_cfg_bank`

## Requirements
- R1: During and after reset, every live and staged register holds its reset value from `RESET_VAL` (register i in bits i*DATA_W upward), `go_pending` is 0 and `commit_done` is 0.
- R2: A write to a register whose `SHADOW_MASK` bit is 1 changes only its staged copy. Its live copy on `active_cfg` stays the same until a switch happens.
- R3: A `go_req` pulse while `go_pending` is 0 sets `go_pending` to 1 from the next cycle. `go_pending` stays 1 until a switch. A `go_req` pulse while it is 1 has no effect.
- R4: When `go_pending` is 1 and the channel's sync pulse is high in a cycle, every masked live register takes its staged value in the next cycle. In that same cycle `go_pending` reads 0.
- R5: A sync pulse while `go_pending` is 0, with no enable edge, leaves `active_cfg` unchanged and does not pulse `commit_done`.
- R6: With `CHAN_KIND` = CH_PANEL the sync pulse is `vfp_start` and `ext_vsync` is ignored. With CH_TV the sync pulse is `ext_vsync` and `vfp_start` is ignored.
- R7: A 0-to-1 transition on `intf_en` causes a switch in the next cycle, whatever the state of `go_pending`, and clears a pending request. A `go_req` pulse in the same cycle as that edge, while `go_pending` is 0, still sets the flag.
- R8: When a staged write and a switch fall in the same cycle, the written register's live copy takes the staged value from before the write. The new value stays in the staged copy.
- R9: A write to a register whose mask bit is 0 appears on its live copy in the next cycle, with or without a switch.
- R10: `rd_data` shows, without a clock delay, the staged copy of the register selected by `rd_addr`. For an unmasked register this is the same as its live copy.
- R11: `commit_done` is high for exactly the cycles in which `active_cfg` shows the result of a switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the staged register selected by cfg_addr |
| cfg_addr | input | AW | Register index for writes |
| cfg_wdata | input | DATA_W | Write data |
| go_req | input | 1 | Software request to switch on the next sync event |
| rd_addr | input | AW | Register index for readback |
| rd_data | output | DATA_W | Staged value of the selected register |
| go_pending | output | 1 | Request flag; 1 while a switch is pending |
| intf_en | input | 1 | Interface enable; a rising edge forces a switch |
| vfp_start | input | 1 | Start of vertical front porch pulse (panel channels) |
| ext_vsync | input | 1 | External vertical sync pulse (TV channel) |
| active_cfg | output | NUM_REGS*DATA_W | Live configuration, register i in bits i*DATA_W upward |
| commit_done | output | 1 | One-cycle pulse in the first cycle of a new live configuration |

## Verification
The bench builds two copies of the block, each with four 8-bit registers, a mask of 4'b1011 so that register 2 writes straight through, and distinct reset bytes. One copy is a panel channel and the other a TV channel. Both copies get the same stimulus, so each sync pulse has to trigger one channel and be ignored by the other. This small size lets the bench sweep every combination of write strobe, request pulse, the two sync pulses and the enable level against every register index. That sweep covers switches that coincide with writes, with new requests and with enable edges.

// File: rtl/cfgbank_pkg.sv
`timescale 1ns/1ps
package cfgbank_pkg;
  typedef enum logic {
    CH_PANEL = 1'b0,
    CH_TV    = 1'b1
  } chan_kind_e;
endpackage

// File: rtl/cfgbank_event.sv
`timescale 1ns/1ps
// Picks the frame-boundary pulse for the channel kind and detects enable edges.
module cfgbank_event #(
  parameter cfgbank_pkg::chan_kind_e CHAN_KIND = cfgbank_pkg::CH_PANEL
) (
  input  logic clk,
  input  logic rst_n,
  input  logic intf_en,
  input  logic vfp_start,
  input  logic ext_vsync,
  output logic sync_evt,
  output logic en_rise
);
  logic en_q;

  assign sync_evt = (CHAN_KIND == cfgbank_pkg::CH_TV) ? ext_vsync : vfp_start;
  assign en_rise  = intf_en & ~en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= intf_en;
  end
endmodule

// File: rtl/cfgbank_go.sv
`timescale 1ns/1ps
// Request flag: set by software, cleared by hardware when the switch happens.
module cfgbank_go (
  input  logic clk,
  input  logic rst_n,
  input  logic go_req,
  input  logic sync_evt,
  input  logic en_rise,
  output logic go_q,
  output logic commit,
  output logic done_q
);
  assign commit = (go_q & sync_evt) | en_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      go_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      go_q   <= (go_q & ~commit) | (go_req & ~go_q);
      done_q <= commit;
    end
  end
endmodule

// File: rtl/cfgbank_slot.sv
`timescale 1ns/1ps
// One double-buffered register: staged copy plus live copy.
module cfgbank_slot #(
  parameter int          DATA_W = 32,
  parameter logic [DATA_W-1:0] RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              commit,
  output logic [DATA_W-1:0] staged_q,
  output logic [DATA_W-1:0] live_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      staged_q <= RST;
      live_q   <= RST;
    end else begin
      if (we)     staged_q <= wdata;
      if (commit) live_q   <= staged_q;
    end
  end
endmodule

// File: rtl/shadow_cfg_bank.sv
`timescale 1ns/1ps
module shadow_cfg_bank #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32,
  parameter logic [NUM_REGS-1:0] SHADOW_MASK = '1,
  parameter logic [NUM_REGS*DATA_W-1:0] RESET_VAL = '0,
  parameter cfgbank_pkg::chan_kind_e CHAN_KIND = cfgbank_pkg::CH_PANEL,
  localparam int AW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [AW-1:0]              cfg_addr,
  input  logic [DATA_W-1:0]          cfg_wdata,
  input  logic                       go_req,
  input  logic [AW-1:0]              rd_addr,
  output logic [DATA_W-1:0]          rd_data,
  output logic                       go_pending,
  input  logic                       intf_en,
  input  logic                       vfp_start,
  input  logic                       ext_vsync,
  output logic [NUM_REGS*DATA_W-1:0] active_cfg,
  output logic                       commit_done
);
  logic sync_evt;
  logic en_rise;
  logic commit;
  logic [DATA_W-1:0] staged [NUM_REGS];

  cfgbank_event #(.CHAN_KIND(CHAN_KIND)) u_event (
    .clk(clk), .rst_n(rst_n), .intf_en(intf_en),
    .vfp_start(vfp_start), .ext_vsync(ext_vsync),
    .sync_evt(sync_evt), .en_rise(en_rise)
  );

  cfgbank_go u_go (
    .clk(clk), .rst_n(rst_n), .go_req(go_req),
    .sync_evt(sync_evt), .en_rise(en_rise),
    .go_q(go_pending), .commit(commit), .done_q(commit_done)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic hit;
    assign hit = cfg_we && (cfg_addr == AW'(i));
    if (SHADOW_MASK[i]) begin : g_shadowed
      cfgbank_slot #(
        .DATA_W(DATA_W),
        .RST(RESET_VAL[i*DATA_W +: DATA_W])
      ) u_slot (
        .clk(clk), .rst_n(rst_n), .we(hit), .wdata(cfg_wdata),
        .commit(commit), .staged_q(staged[i]),
        .live_q(active_cfg[i*DATA_W +: DATA_W])
      );
    end else begin : g_direct
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)   q <= RESET_VAL[i*DATA_W +: DATA_W];
        else if (hit) q <= cfg_wdata;
      end
      assign staged[i] = q;
      assign active_cfg[i*DATA_W +: DATA_W] = q;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_addr == AW'(i)) rd_data = staged[i];
  end
endmodule

// File: rtl/shadow_cfg_bank_chk.sv
`timescale 1ns/1ps
module shadow_cfg_bank_chk #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32,
  parameter logic [NUM_REGS-1:0] SHADOW_MASK = '1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       sync_evt,
  input logic                       en_rise,
  input logic                       commit,
  input logic                       go_pending,
  input logic                       commit_done,
  input logic [NUM_REGS*DATA_W-1:0] active_cfg
);
  // R4: a pending request meeting the sync pulse switches and drops the flag
  assert_go_switch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (go_pending && sync_evt) |=> (!go_pending && commit_done));

  // R5: sync with no request and no enable edge does nothing
  assert_idle_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!go_pending && sync_evt && !en_rise) |=> !commit_done);

  // R7: enable edge always switches
  assert_enable_switch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> commit_done);

  // R3: the flag holds until a switch
  assert_go_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (go_pending && !commit) |=> go_pending);

  // R2 and R11: masked live registers move only on a switch cycle
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_stable
    if (SHADOW_MASK[i]) begin : g_m
      assert_live_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_done |-> $stable(active_cfg[i*DATA_W +: DATA_W]));
    end
  end
endmodule

bind shadow_cfg_bank shadow_cfg_bank_chk #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .SHADOW_MASK(SHADOW_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_evt(sync_evt), .en_rise(en_rise),
  .commit(commit), .go_pending(go_pending), .commit_done(commit_done),
  .active_cfg(active_cfg)
);

// File: tb/shadow_cfg_bank_tb.sv
`timescale 1ns/1ps
module shadow_cfg_bank_tb;
  localparam int N = 4;
  localparam int W = 8;
  localparam logic [N-1:0]   MASK = 4'b1011;
  localparam logic [N*W-1:0] RSTV = 32'h44332211;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [W-1:0] cfg_wdata = '0;
  logic go_req = 1'b0;
  logic [1:0] rd_addr = '0;
  logic intf_en = 1'b0;
  logic vfp_start = 1'b0;
  logic ext_vsync = 1'b0;
  logic [W-1:0] rd_p, rd_t;
  logic go_p, go_t, done_p, done_t;
  logic [N*W-1:0] act_p, act_t;

  always #5 clk = ~clk;

  shadow_cfg_bank #(.NUM_REGS(N), .DATA_W(W), .SHADOW_MASK(MASK), .RESET_VAL(RSTV),
                    .CHAN_KIND(cfgbank_pkg::CH_PANEL)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .go_req(go_req), .rd_addr(rd_addr), .rd_data(rd_p), .go_pending(go_p),
    .intf_en(intf_en), .vfp_start(vfp_start), .ext_vsync(ext_vsync),
    .active_cfg(act_p), .commit_done(done_p));

  shadow_cfg_bank #(.NUM_REGS(N), .DATA_W(W), .SHADOW_MASK(MASK), .RESET_VAL(RSTV),
                    .CHAN_KIND(cfgbank_pkg::CH_TV)) u_dut_tv (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .go_req(go_req), .rd_addr(rd_addr), .rd_data(rd_t), .go_pending(go_t),
    .intf_en(intf_en), .vfp_start(vfp_start), .ext_vsync(ext_vsync),
    .active_cfg(act_t), .commit_done(done_t));

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;
  logic [W-1:0] exp_sh [N];
  logic [W-1:0] exp_act [2][N];
  logic exp_go [2];
  logic exp_done [2];
  logic en_prev = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [N*W-1:0] pack_act(input int k);
    logic [N*W-1:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = exp_act[k][i];
    return v;
  endfunction

  task automatic check_outputs(input string tag);
    check({tag, " live panel"}, act_p, pack_act(0));
    check({tag, " live tv"}, act_t, pack_act(1));
    check({tag, " go panel"}, {31'b0, go_p}, {31'b0, exp_go[0]});
    check({tag, " go tv"}, {31'b0, go_t}, {31'b0, exp_go[1]});
    check({tag, " R11 done panel"}, {31'b0, done_p}, {31'b0, exp_done[0]});
    check({tag, " R11 done tv"}, {31'b0, done_t}, {31'b0, exp_done[1]});
  endtask

  task automatic readback(input string tag);
    for (int i = 0; i < N; i++) begin
      rd_addr = 2'(i);
      #1;
      check({tag, " R10 readback"}, {24'b0, rd_p}, {24'b0, exp_sh[i]});
      check({tag, " R10 readback tv"}, {24'b0, rd_t}, {24'b0, exp_sh[i]});
    end
  endtask

  // One cycle of stimulus, driven at a falling edge, checked at the next one.
  task automatic step(input string tag, input logic we, input logic [1:0] a,
                      input logic [W-1:0] d, input logic g, input logic v,
                      input logic s, input logic e);
    logic rise, sync, c;
    cfg_we = we; cfg_addr = a; cfg_wdata = d; go_req = g;
    vfp_start = v; ext_vsync = s; intf_en = e;
    rise = e & ~en_prev;
    en_prev = e;
    for (int k = 0; k < 2; k++) begin
      sync = (k == 0) ? v : s;
      c = (exp_go[k] & sync) | rise;
      for (int i = 0; i < N; i++) begin
        if (MASK[i]) begin
          if (c) exp_act[k][i] = exp_sh[i];
        end else if (we && a == 2'(i)) begin
          exp_act[k][i] = d;
        end
      end
      exp_go[k] = (exp_go[k] & ~c) | (g & ~exp_go[k]);
      exp_done[k] = c;
    end
    if (we) exp_sh[a] = d;
    @(negedge clk);
    cfg_we = 1'b0; go_req = 1'b0; vfp_start = 1'b0; ext_vsync = 1'b0;
    check_outputs(tag);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      exp_sh[i] = RSTV[i*W +: W];
      exp_act[0][i] = RSTV[i*W +: W];
      exp_act[1][i] = RSTV[i*W +: W];
    end
    for (int k = 0; k < 2; k++) begin exp_go[k] = 1'b0; exp_done[k] = 1'b0; end
    repeat (3) @(negedge clk);
    check_outputs("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_outputs("R1 after reset");
    readback("R1");

    // R2 / R9: stage new values in every register, no switch
    for (int i = 0; i < N; i++)
      step("R2 R9 staged write", 1'b1, 2'(i), 8'hA0 + 8'(i), 1'b0, 1'b0, 1'b0, 1'b0);
    readback("R2");

    // R5: sync pulses with no request
    step("R5 idle vfp", 1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    step("R5 idle vsync", 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);

    // R3: request, then repeated request while pending
    step("R3 go set", 1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
    step("R3 go repeat", 1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
    step("R3 go hold", 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);

    // R6: only the TV channel reacts to ext_vsync, only the panel to vfp_start
    step("R6 vsync", 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
    step("R6 R4 vfp", 1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);

    // R8: a staged write in the switch cycle
    step("R8 go set", 1'b1, 2'd1, 8'h5C, 1'b1, 1'b0, 1'b0, 1'b0);
    step("R8 write at switch", 1'b1, 2'd1, 8'hC5, 1'b0, 1'b1, 1'b1, 1'b0);
    readback("R8");

    // R7: enable edge with and without a request
    step("R7 enable edge", 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
    step("R7 enable low", 1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
    step("R7 edge clears go", 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
    step("R7 enable low again", 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    step("R7 edge with request", 1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1);

    // R4: sweep every mix of write, request, both syncs and enable level
    for (int pass = 0; pass < 4; pass++) begin
      for (int p = 0; p < 32; p++) begin
        step("R4 sweep", p[0], 2'(p + pass), 8'(p * 7 + pass * 53 + 3),
             p[1], p[2], p[3], p[4] ^ pass[0]);
      end
      readback("R4 sweep");
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule